// File: doc/BRIEF.md
# CAN Remote Frame Buffer Matcher

This block decides where an incoming remote frame lands in a CAN controller with a bank of message buffers. A frame decoder hands it the received identifier and DLC with a one-cycle strobe. The block looks at every buffer's configuration and status bits and finds the transmit buffers that can accept the request. It picks the lowest-numbered one whose stored identifier equals the received one.

One clock edge after the strobe, the block drives its update outputs. A one-hot select marks the winning buffer, whose DLC field takes the received value and whose done flag is set. The block also drives a pulse that sets the global receive interrupt status, a receive-complete interrupt pulse, and a push of the buffer number into the receive history list. The block has no path that writes a buffer's data bytes, so a remote frame leaves them as they were. The buffer's overwrite-control bit and the controller's operating mode do not change the outcome.

Top module: `can_rmt_match`

## Requirements
- R1: A buffer is eligible only if its enable bit is 1, its 3-bit type field is 000 (transmit), its ready bit is 1, its RTR bit is 0 and its transmit-request bit is 0.
- R2: Only an eligible buffer whose stored identifier equals `rf_id` in every bit can be selected.
- R3: When several eligible buffers match, the one with the lowest index is selected.
- R4: On the clock edge that samples `rf_valid` high with a selection, `upd_sel` becomes one-hot on the winner and `upd_dlc` carries `rf_dlc`, for exactly one cycle.
- R5: The per-buffer overwrite bits `buf_ows` have no effect on any output.
- R6: `ints_set` pulses with a selection only when the winner's `buf_ie` bit is 1.
- R7: `rx_irq` pulses with a selection only when the winner's `buf_ie` bit and `glob_rx_ie` are both 1.
- R8: With every selection, `hist_push` pulses once and `hist_num` gives the winner's index (0 to NBUF-1).
- R9: `op_mode` has no effect on any output.
- R10: Without a strobe, or when no eligible buffer matches, all outputs stay 0.
- R11: While reset is asserted, and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_valid | input | 1 | Strobe: a remote frame has been received |
| rf_id | input | IDW | Received identifier |
| rf_dlc | input | 4 | Received DLC |
| op_mode | input | 2 | Controller operating mode (no effect) |
| buf_en | input | NBUF | Buffer is in use as a message buffer |
| buf_type | input | 3*NBUF | Buffer type field, 3 bits per buffer, 000 = transmit |
| buf_rdy | input | NBUF | Buffer ready bit |
| buf_rtr | input | NBUF | Buffer's own RTR setting |
| buf_trq | input | NBUF | Buffer transmit request pending |
| buf_ows | input | NBUF | Buffer overwrite control (no effect) |
| buf_ie | input | NBUF | Buffer interrupt enable |
| buf_id | input | IDW*NBUF | Stored identifiers, IDW bits per buffer |
| glob_rx_ie | input | 1 | Global receive interrupt enable |
| upd_sel | output | NBUF | One-hot: write DLC and set done flag of this buffer |
| upd_dlc | output | 4 | DLC value to write |
| ints_set | output | 1 | Set the global receive interrupt status |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| hist_push | output | 1 | Push an entry to the receive history list |
| hist_num | output | log2(NBUF) | Buffer number for the history entry |

## Verification
Every result of a strobe shows up at the first rising edge after `rf_valid` is sampled high and lasts one cycle. The bench drives inputs on falling edges and records which edges sampled a strobe. At the falling edge that follows such an edge, it compares all six outputs against the expected item at the front of the queue. At every other falling edge it checks that all outputs are 0, so an output that comes late or stays high is reported.

// File: rtl/can_rmt_match.sv
module can_rmt_match #(
  parameter int NBUF = 32,
  parameter int IDW  = 29
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rf_valid,
  input  logic [IDW-1:0]         rf_id,
  input  logic [3:0]             rf_dlc,
  input  logic [1:0]             op_mode,
  input  logic [NBUF-1:0]        buf_en,
  input  logic [3*NBUF-1:0]      buf_type,
  input  logic [NBUF-1:0]        buf_rdy,
  input  logic [NBUF-1:0]        buf_rtr,
  input  logic [NBUF-1:0]        buf_trq,
  input  logic [NBUF-1:0]        buf_ows,
  input  logic [NBUF-1:0]        buf_ie,
  input  logic [IDW*NBUF-1:0]    buf_id,
  input  logic                   glob_rx_ie,
  output logic [NBUF-1:0]        upd_sel,
  output logic [3:0]             upd_dlc,
  output logic                   ints_set,
  output logic                   rx_irq,
  output logic                   hist_push,
  output logic [$clog2(NBUF)-1:0] hist_num
);
  localparam int NW = $clog2(NBUF);

  logic [NBUF-1:0] hit;
  logic [NBUF-1:0] win_sel;
  logic [NW-1:0]   win_idx;
  logic            found;
  logic            take;
  logic            unused_ign;

  for (genvar i = 0; i < NBUF; i++) begin : g_cmp
    assign hit[i] = buf_en[i] && (buf_type[3*i +: 3] == 3'b000) && buf_rdy[i] &&
                    !buf_rtr[i] && !buf_trq[i] && (buf_id[IDW*i +: IDW] == rf_id);
  end

  assign found   = |hit;
  assign win_sel = hit & (~hit + 1'b1);
  assign take    = rf_valid && found;
  assign unused_ign = ^{op_mode, buf_ows};

  always_comb begin
    win_idx = '0;
    for (int i = NBUF-1; i >= 0; i--)
      if (hit[i]) win_idx = NW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_sel   <= '0;
      upd_dlc   <= '0;
      ints_set  <= 1'b0;
      rx_irq    <= 1'b0;
      hist_push <= 1'b0;
      hist_num  <= '0;
    end else begin
      upd_sel   <= take ? win_sel : '0;
      upd_dlc   <= take ? rf_dlc : '0;
      ints_set  <= take && buf_ie[win_idx];
      rx_irq    <= take && buf_ie[win_idx] && glob_rx_ie;
      hist_push <= take;
      hist_num  <= take ? win_idx : '0;
    end
  end

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_sel));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_valid |=> (upd_sel == '0 && !ints_set && !rx_irq && !hist_push));
  p_push_matches_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hist_push |-> (upd_sel == (NBUF'(1) << hist_num)));
  p_sel_needs_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_sel != '0) |-> hist_push);
  p_ints_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n) ints_set |-> hist_push);
  p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (ints_set && $past(glob_rx_ie)));
endmodule

// File: tb/can_rmt_match_bench.sv
module can_rmt_match_bench;
  localparam int NB  = 32;
  localparam int IDW = 29;
  localparam int NW  = 5;

  typedef struct {
    logic [NB-1:0] sel;
    logic [3:0]    dlc;
    logic          ints, irq, push;
    logic [NW-1:0] num;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0, rf_valid = 0, glob_ie = 0;
  logic [IDW-1:0] rf_id = '0;
  logic [3:0] rf_dlc = '0;
  logic [1:0] op_mode = '0;
  logic [NB-1:0] en = '0, rdy = '0, rtr = '0, trq = '0, ows = '0, ie = '0;
  logic [3*NB-1:0] typ = '0;
  logic [IDW-1:0] ids [NB];
  logic [IDW*NB-1:0] idflat;
  logic [NB-1:0] upd_sel;
  logic [3:0] upd_dlc;
  logic ints_set, rx_irq, hist_push;
  logic [NW-1:0] hist_num;

  int vectors = 0, errors = 0;
  bit fired = 0, done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NB; i++) idflat[IDW*i +: IDW] = ids[i];

  can_rmt_match #(.NBUF(NB), .IDW(IDW)) u_can_rmt_match (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_id(rf_id), .rf_dlc(rf_dlc),
    .op_mode(op_mode), .buf_en(en), .buf_type(typ), .buf_rdy(rdy), .buf_rtr(rtr),
    .buf_trq(trq), .buf_ows(ows), .buf_ie(ie), .buf_id(idflat), .glob_rx_ie(glob_ie),
    .upd_sel(upd_sel), .upd_dlc(upd_dlc), .ints_set(ints_set), .rx_irq(rx_irq),
    .hist_push(hist_push), .hist_num(hist_num));

  always @(posedge clk) fired <= rst_n && rf_valid;

  task automatic cmp(exp_t e);
    logic [NB+11:0] act, ex;
    act = {upd_sel, upd_dlc, ints_set, rx_irq, hist_push, hist_num};
    ex  = {e.sel, e.dlc, e.ints, e.irq, e.push, e.num};
    vectors++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", e.tag, act, ex);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    exp_t e;
    if (fired) begin
      if (q.size() == 0) begin
        e.tag = "R10 unexpected strobe"; e.sel = '0; e.dlc = '0; e.ints = 0; e.irq = 0; e.push = 0; e.num = '0;
      end else e = q.pop_front();
    end else begin
      e.tag = "R10 idle"; e.sel = '0; e.dlc = '0; e.ints = 0; e.irq = 0; e.push = 0; e.num = '0;
    end
    cmp(e);
  end

  function automatic exp_t model(logic [IDW-1:0] id, logic [3:0] dlc, string tag);
    exp_t e;
    e.tag = tag; e.sel = '0; e.dlc = '0; e.ints = 0; e.irq = 0; e.push = 0; e.num = '0;
    for (int i = 0; i < NB; i++)
      if (en[i] && typ[3*i +: 3] == 3'b000 && rdy[i] && !rtr[i] && !trq[i] && ids[i] == id) begin
        e.sel[i] = 1'b1; e.dlc = dlc; e.ints = ie[i]; e.irq = ie[i] && glob_ie;
        e.push = 1; e.num = NW'(i);
        return e;
      end
    return e;
  endfunction

  task automatic strobe(logic [IDW-1:0] id, logic [3:0] dlc, string tag);
    @(negedge clk);
    rf_id = id; rf_dlc = dlc; rf_valid = 1;
    q.push_back(model(id, dlc, tag));
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic clear_all();
    en = '0; rdy = '0; rtr = '0; trq = '0; ows = '0; ie = '0; typ = '1;
    for (int i = 0; i < NB; i++) ids[i] = IDW'(i);
  endtask

  task automatic mk(int i, logic [IDW-1:0] id);
    en[i] = 1; typ[3*i +: 3] = 3'b000; rdy[i] = 1; rtr[i] = 0; trq[i] = 0; ids[i] = id;
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    vectors++;
    if ({upd_sel, upd_dlc, ints_set, rx_irq, hist_push, hist_num} !== '0) begin
      errors++; $display("FAIL R11 reset: actual nonzero expected 0");
    end
    rst_n = 1;
    @(negedge clk);

    mk(5, 29'h123); ie[5] = 1; glob_ie = 1;
    strobe(29'h123, 4'd8, "R2 R4 R7 R8 single match");
    strobe(29'h122, 4'd8, "R2 id off by one bit");
    strobe(29'h123, 4'd3, "R4 new dlc back-to-back");

    en[5] = 0;            strobe(29'h123, 4'd1, "R1 disabled"); en[5] = 1;
    typ[15 +: 3] = 3'b001; strobe(29'h123, 4'd1, "R1 type 001"); typ[15 +: 3] = 3'b100;
    strobe(29'h123, 4'd1, "R1 type 100"); typ[15 +: 3] = 3'b000;
    rdy[5] = 0;           strobe(29'h123, 4'd1, "R1 not ready"); rdy[5] = 1;
    rtr[5] = 1;           strobe(29'h123, 4'd1, "R1 rtr set"); rtr[5] = 0;
    trq[5] = 1;           strobe(29'h123, 4'd1, "R1 trq pending"); trq[5] = 0;
    strobe(29'h123, 4'd15, "R1 eligible again");

    mk(9, 29'h2A5); mk(20, 29'h2A5); ie[9] = 1; ie[20] = 1;
    strobe(29'h2A5, 4'd6, "R3 lowest of two");
    trq[9] = 1; strobe(29'h2A5, 4'd7, "R3 next after blocked"); trq[9] = 0;

    glob_ie = 0; strobe(29'h2A5, 4'd2, "R7 global ie off");
    ie[9] = 0;   strobe(29'h2A5, 4'd2, "R6 buffer ie off");
    glob_ie = 1; strobe(29'h2A5, 4'd2, "R6 R7 buffer ie off global on");
    ie[9] = 1;

    ows = '1; strobe(29'h2A5, 4'd4, "R5 ows all set");
    ows = '0; strobe(29'h2A5, 4'd4, "R5 ows all clear");

    for (int m = 0; m < 4; m++) begin
      op_mode = 2'(m);
      strobe(29'h123, 4'd9, "R9 mode sweep");
    end
    op_mode = '0;

    mk(31, 29'h1FFFFFFF); ie[31] = 1;
    strobe(29'h1FFFFFFF, 4'd11, "R8 buffer 31");
    mk(0, 29'h0); strobe(29'h0, 4'd12, "R8 buffer 0");
    strobe(29'h777, 4'd5, "R10 no match");

    for (int n = 0; n < 80; n++) begin
      for (int i = 0; i < NB; i++) begin
        en[i] = ($urandom_range(3) != 0); rdy[i] = ($urandom_range(3) != 0);
        rtr[i] = ($urandom_range(5) == 0); trq[i] = ($urandom_range(5) == 0);
        typ[3*i +: 3] = ($urandom_range(4) == 0) ? 3'($urandom_range(7)) : 3'b000;
        ie[i] = $urandom_range(1); ows[i] = $urandom_range(1);
        ids[i] = IDW'(29'h100 + $urandom_range(3));
      end
      glob_ie = $urandom_range(1); op_mode = 2'($urandom_range(3));
      strobe(IDW'(29'h100 + $urandom_range(4)), 4'($urandom_range(15)), "R1 R3 R6 R7 random");
    end

    repeat (3) @(negedge clk);
    vectors++;
    if (q.size() != 0) begin
      errors++; $display("FAIL R4: actual %0d results missing expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1; errors++; vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule